// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

This block turns a four-bit BCD digit into seven active-high segment drives (a to g) for a common-cathode display. A storage register sits in front of the decoder. While the hold input is low, the register loads the digit on every clock. While hold is high, the register keeps the last digit it loaded. Codes above 9 give a dark display.

Two active-low overrides act after the register, on the decoded pattern. Lamp test lights every segment and takes priority over everything else. Blanking darkens every segment and takes priority over the decoded digit. Neither override changes the stored code. Both reach the outputs without waiting for a clock edge.

Top module: `bcd7_latch_dec`

## Requirements
- R1: A synchronous active-high reset clears the stored code to 0. With both overrides inactive, `seg` then shows 1111110.
- R2: While `hold` is low, the stored code loads `digit` at every rising clock edge. The output therefore follows `digit` one clock later and does not change before that edge.
- R3: While `hold` is high, the stored code keeps its value. Changes on `digit` leave `seg` unchanged.
- R4: When `test_n` is low, `seg` is 1111111, whatever the other inputs and the stored code are.
- R5: When `test_n` is high and `blank_n` is low, `seg` is 0000000, whatever the data and hold inputs are.
- R6: With both overrides high, codes 0 to 5 decode as follows. `seg[6]` is segment a and `seg[0]` is segment g. 0 gives 1111110, 1 gives 0110000, 2 gives 1101101, 3 gives 1111001, 4 gives 0110011 and 5 gives 1011011.
- R7: With both overrides high, codes 6 to 9 decode as follows. 6 gives 0011111 (no top bar), 7 gives 1110000, 8 gives 1111111 and 9 gives 1110011 (no bottom bar).
- R8: With both overrides high, stored codes 10 to 15 give 0000000.
- R9: Asserting lamp test or blanking does not alter the stored code. Once both overrides are released, the pattern for the held code returns.
- R10: A change on `test_n` or `blank_n` reaches `seg` within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | High keeps the stored code; low loads `digit` every clock |
| blank_n | input | 1 | Active-low blanking of all segments |
| test_n | input | 1 | Active-low lamp test, lights all segments |
| digit | input | DIG_W | BCD digit input |
| seg | output | 7 | Segments a..g, a in bit 6, active high |

## Verification
The bench builds the block with its default `DIG_W` of 4. With that width the sweep covers every input code, including all six illegal ones. Each code is loaded and then seen under all four combinations of lamp test and blanking.

Further sequences test the following:
- with hold raised, the stored digit survives data changes and pulses on the overrides;
- the output lags the data by one clock edge;
- the overrides take effect with no clock edge.

// File: rtl/bcd7_latch_dec.sv
`timescale 1ns/1ps
module bcd7_latch_dec #(
  parameter int DIG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             blank_n,
  input  logic             test_n,
  input  logic [DIG_W-1:0] digit,
  output logic [6:0]       seg
);
  localparam int SEG_N = 7;

  logic [DIG_W-1:0] code_q;
  logic [SEG_N-1:0] pat;

  always_ff @(posedge clk) begin
    if (rst)       code_q <= '0;
    else if (!hold) code_q <= digit;
  end

  always_comb begin
    case (code_q)
      DIG_W'(0): pat = 7'b1111110;
      DIG_W'(1): pat = 7'b0110000;
      DIG_W'(2): pat = 7'b1101101;
      DIG_W'(3): pat = 7'b1111001;
      DIG_W'(4): pat = 7'b0110011;
      DIG_W'(5): pat = 7'b1011011;
      DIG_W'(6): pat = 7'b0011111;
      DIG_W'(7): pat = 7'b1110000;
      DIG_W'(8): pat = 7'b1111111;
      DIG_W'(9): pat = 7'b1110011;
      default:   pat = 7'b0000000;
    endcase
  end

  assign seg = !test_n  ? {SEG_N{1'b1}} :
               !blank_n ? {SEG_N{1'b0}} : pat;
endmodule

// File: rtl/bcd7_latch_dec_chk.sv
`timescale 1ns/1ps
module bcd7_latch_dec_chk #(
  parameter int DIG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             hold,
  input logic             blank_n,
  input logic             test_n,
  input logic [DIG_W-1:0] digit,
  input logic [DIG_W-1:0] code_q,
  input logic [6:0]       seg
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> code_q == '0); // R1
  AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (rst) !hold |=> code_q == $past(digit)); // R2
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst) hold |=> $stable(code_q)); // R3
  AST_LAMP_ALL_ON: assert property (@(posedge clk) disable iff (rst) !test_n |-> seg == 7'h7f); // R4
  AST_BLANK_ALL_OFF: assert property (@(posedge clk) disable iff (rst) (test_n && !blank_n) |-> seg == 7'h00); // R5
  AST_ILLEGAL_DARK: assert property (@(posedge clk) disable iff (rst) (test_n && blank_n && code_q > DIG_W'(9)) |-> seg == 7'h00); // R8
endmodule

bind bcd7_latch_dec bcd7_latch_dec_chk #(.DIG_W(DIG_W)) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .blank_n(blank_n), .test_n(test_n),
  .digit(digit), .code_q(code_q), .seg(seg)
);

// File: tb/sim_bcd7_latch_dec.sv
`timescale 1ns/1ps
module sim_bcd7_latch_dec;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold = 1'b1;
  logic       blank_n = 1'b1;
  logic       test_n = 1'b1;
  logic [3:0] digit = 4'd0;
  logic [6:0] seg;

  int checks = 0;
  int fails = 0;
  logic [3:0] model = 4'd0;
  logic [6:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  bcd7_latch_dec #(.DIG_W(4)) u0 (
    .clk(clk), .rst(rst), .hold(hold), .blank_n(blank_n),
    .test_n(test_n), .digit(digit), .seg(seg)
  );

  function automatic logic [6:0] shape(input logic [3:0] c);
    case (c)
      4'd0: return 7'b1111110;
      4'd1: return 7'b0110000;
      4'd2: return 7'b1101101;
      4'd3: return 7'b1111001;
      4'd4: return 7'b0110011;
      4'd5: return 7'b1011011;
      4'd6: return 7'b0011111;
      4'd7: return 7'b1110000;
      4'd8: return 7'b1111111;
      4'd9: return 7'b1110011;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic logic [6:0] expect_seg(input logic [3:0] c, input logic t, input logic b);
    if (!t) return 7'h7f;
    if (!b) return 7'h00;
    return shape(c);
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s seg=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] d, input logic h, input logic b, input logic t, input string tag);
    @(negedge clk);
    digit = d; hold = h; blank_n = b; test_n = t;
    if (!h) model = d;
    exp_q.push_back(expect_seg(model, t, b));
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), seg, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model = 4'd0;
    drive(4'd9, 1'b1, 1'b1, 1'b1, "R1 reset shows 0");

    for (int c = 0; c < 16; c++) begin
      drive(4'(c), 1'b0, 1'b1, 1'b1, c < 6 ? "R6 decode" : (c < 10 ? "R7 decode" : "R8 illegal dark"));
      drive(4'(c), 1'b1, 1'b0, 1'b1, "R5 blank");
      drive(4'(c), 1'b1, 1'b1, 1'b0, "R4 lamp test");
      drive(4'(c), 1'b1, 1'b0, 1'b0, "R4 lamp over blank");
    end

    drive(4'd3, 1'b0, 1'b1, 1'b1, "R2 load 3");
    drive(4'd8, 1'b1, 1'b1, 1'b1, "R3 hold vs 8");
    drive(4'd1, 1'b1, 1'b1, 1'b1, "R3 hold vs 1");
    drive(4'd1, 1'b1, 1'b1, 1'b0, "R9 lamp pulse");
    drive(4'd6, 1'b1, 1'b0, 1'b1, "R9 blank pulse");
    drive(4'd6, 1'b1, 1'b1, 1'b1, "R9 code kept");

    drive(4'd7, 1'b0, 1'b1, 1'b1, "R2 load 7");
    @(negedge clk);
    exp_q.delete(); tag_q.delete();
    digit = 4'd5; hold = 1'b0;
    #0.5 check("R2 no change before edge", seg, shape(4'd7));
    @(posedge clk); #1 check("R2 one clock lag", seg, shape(4'd5));
    model = 4'd5;

    @(negedge clk);
    hold = 1'b1;
    test_n = 1'b0;
    #0.5 check("R10 lamp test immediate", seg, 7'h7f);
    test_n = 1'b1; blank_n = 1'b0;
    #0.5 check("R10 blank immediate", seg, 7'h00);
    blank_n = 1'b1;
    #0.5 check("R10 release immediate", seg, shape(4'd5));

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule